// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Distributed Refresh

This block connects a simple host request port to an asynchronous 1M-word by 4-bit DRAM. The DRAM has a shared 10-bit address bus and active-low row strobe, column strobe, write enable and output enable. A host request carries a 20-bit word address, a write flag and 4-bit write data, and is taken on a clock edge where `req_valid` and `req_ready` are both high. The upper ten address bits select the row and the lower ten select the column. A read returns its nibble on `rd_data` with a one-cycle `rd_valid` pulse. Results come back in request order.

After an access the row stays open. A following request to the same row then needs only a column cycle, which is a fast page cycle. The row is closed in three cases: a request names another row, a refresh is due, or the row has been active close to its maximum low time. Refresh uses the column-before-row order, so the DRAM counts rows itself and no refresh address is needed. A refresh interval timer raises a pending flag. A pending refresh takes priority over any host request. All timing minimums are parameters given in clock cycles.

The state machine has these states:
- PWRUP: power-up pause.
- IDLE: row closed.
- ACT: row strobe low with the row address driven.
- CSET: column address and write enable set up.
- COL: column strobe low.
- PAGE: row open, column strobe high.
- PRE: row precharge.
- REFC: column strobe low ahead of refresh.
- REFR: both strobes low for refresh.

The transitions are:
- PWRUP→REFC when the pause ends.
- IDLE→REFC when initial refreshes remain or a refresh is pending.
- IDLE→ACT when a request is accepted.
- ACT→CSET after the row-to-column delay.
- CSET→COL after one cycle.
- COL→PAGE after the column pulse.
- PAGE→CSET when a same-row request is accepted.
- PAGE→PRE when a refresh is pending, the row age limit is reached, or a request names another row.
- PRE→IDLE after precharge.
- REFC→REFR after the column-to-row setup.
- REFR→PRE when the refresh pulse ends.

Top module: `page_dram_ctrl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1 and `req_ready` is 0 for at least T_PWRUP cycles.
- R2: At least N_INIT_REF column-before-row refresh cycles occur before `req_ready` is first 1.
- R3: At each row strobe fall of an access, `dram_a` equals address bits 19:10. At each column strobe fall of an access, `dram_a` equals bits 9:0.
- R4: For a write, `dram_we_n` is 0 for at least one cycle before the column strobe falls. `dram_dq_oe` is 1 and `dram_dq_out` holds the write data while the column strobe is low. `dram_oe_n` stays 1 whenever `dram_we_n` is 0.
- R5: A read returns on `rd_data`, with `rd_valid` high for exactly one cycle, the nibble last written to that address, or 0 if the address was never written. Results come back in request order.
- R6: Consecutive requests to one row with no refresh between them share a single row strobe fall.
- R7: The row strobe is high for at least T_RP cycles before each of its falls.
- R8: The row strobe is never low for more than T_RAS_MAX consecutive cycles. A long same-row sequence therefore reopens the row.
- R9: The row strobe is low for at least T_RCD cycles before an access's column strobe falls. The column strobe is low for at least T_CAS cycles per access and high for at least T_CP cycles between accesses.
- R10: A refresh is marked by the column strobe falling while the row strobe is high. The column strobe stays low for at least T_CSR cycles before the row strobe falls, and `dram_we_n` is 1 during the refresh.
- R11: After initialisation, successive refresh starts are at most REF_INTERVAL+32 cycles apart, even while requests keep arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request is taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row in 19:10, column in 9:0 |
| req_wdata | input | 4 | Write nibble |
| rd_data | output | 4 | Read nibble |
| rd_valid | output | 1 | One-cycle read result strobe |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 4 | Data returned by the DRAM |

## Verification
The assertions assume the DRAM drives valid read data on `dram_dq_in` from the half cycle after the column strobe and output enable both go low until they rise. The bench's memory model does this, and it drives a fixed wrong nibble at all other times. The assertions also assume that host inputs stay constant while `req_valid` waits for `req_ready`. The bench changes inputs only on falling edges, and holds them until the accepting edge.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_ACT,
        ST_CSET,
        ST_COL,
        ST_PAGE,
        ST_PRE,
        ST_REFC,
        ST_REFR
    } pdc_state_e;
endpackage

// File: rtl/pdc_delay.sv
// Down-counter that times the stay in a state; done when it reaches zero.
module pdc_delay #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pdc_ref_timer.sv
// Raises a pending refresh every INTERVAL cycles; cleared by ack.
module pdc_ref_timer #(
    parameter int INTERVAL = 1900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(INTERVAL + 1);
    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(INTERVAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            cnt <= wrap ? '0 : cnt + 1'b1;
            if (wrap)
                pend <= 1'b1;
            else if (ack)
                pend <= 1'b0;
        end
    end

    // R11
    ack_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> pend);
endmodule

// File: rtl/pdc_row_age.sv
// Counts cycles the row strobe has been low; flags when the row must close.
module pdc_row_age #(
    parameter int LIMIT = 1200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);
    localparam int AW = $clog2(LIMIT + 1);
    logic [AW-1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age <= '0;
        else if (!active)
            age <= '0;
        else if (age != AW'(LIMIT))
            age <= age + 1'b1;
    end

    assign expired = (age == AW'(LIMIT));
endmodule

// File: rtl/page_dram_ctrl.sv
module page_dram_ctrl
    import pdc_pkg::*;
#(
    parameter int ROW_W        = 10,
    parameter int DQ_W         = 4,
    parameter int T_PWRUP      = 25000,
    parameter int N_INIT_REF   = 8,
    parameter int REF_INTERVAL = 1900,
    parameter int T_RAS_MAX    = 1250,
    parameter int T_RP         = 8,
    parameter int T_RCD        = 3,
    parameter int T_CAS        = 3,
    parameter int T_CP         = 2,
    parameter int T_CSR        = 2,
    parameter int T_RASR       = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [2*ROW_W-1:0]   req_addr,
    input  logic [DQ_W-1:0]      req_wdata,
    output logic [DQ_W-1:0]      rd_data,
    output logic                 rd_valid,
    output logic [ROW_W-1:0]     dram_a,
    output logic                 dram_ras_n,
    output logic                 dram_cas_n,
    output logic                 dram_we_n,
    output logic                 dram_oe_n,
    output logic [DQ_W-1:0]      dram_dq_out,
    output logic                 dram_dq_oe,
    input  logic [DQ_W-1:0]      dram_dq_in
);
    localparam int DLY_W   = $clog2(T_PWRUP + T_RP + T_RCD + T_CAS + T_CP + T_CSR + T_RASR + 1);
    localparam int GUARD   = T_CAS + T_CP + 4;
    localparam int AGE_LIM = T_RAS_MAX - GUARD;
    localparam int INIT_W  = $clog2(N_INIT_REF + 1);
    localparam int RASC_W  = $clog2(T_RAS_MAX + 2);

    pdc_state_e state, nxt;

    logic [ROW_W-1:0]  row_q, col_q;
    logic              wr_q;
    logic [DQ_W-1:0]   wd_q;
    logic [INIT_W-1:0] init_left;

    logic              dly_load, dly_done;
    logic [DLY_W-1:0]  dly_val;
    logic              ref_pend, ref_ack;
    logic              row_active, row_expired;
    logic              accept, rd_cap, same_row, init_done;

    assign init_done = (init_left == '0);
    assign same_row  = (req_addr[2*ROW_W-1:ROW_W] == row_q);

    pdc_delay #(.W(DLY_W), .RST_VAL(T_PWRUP - 1)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dly_load),
        .value (dly_val),
        .done  (dly_done)
    );

    pdc_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ref_ack),
        .pend  (ref_pend)
    );

    pdc_row_age #(.LIMIT(AGE_LIM)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (row_active),
        .expired (row_expired)
    );

    // ---------------- next state ----------------
    always_comb begin
        nxt       = state;
        dly_load  = 1'b0;
        dly_val   = '0;
        accept    = 1'b0;
        ref_ack   = 1'b0;
        rd_cap    = 1'b0;
        req_ready = 1'b0;
        unique case (state)
            ST_PWRUP: if (dly_done) begin
                nxt = ST_REFC; dly_load = 1'b1; dly_val = DLY_W'(T_CSR - 1);
            end
            ST_IDLE: begin
                if (!init_done || ref_pend) begin
                    nxt = ST_REFC; dly_load = 1'b1; dly_val = DLY_W'(T_CSR - 1);
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        accept = 1'b1; nxt = ST_ACT;
                        dly_load = 1'b1; dly_val = DLY_W'(T_RCD - 1);
                    end
                end
            end
            ST_ACT: if (dly_done) nxt = ST_CSET;
            ST_CSET: begin
                nxt = ST_COL; dly_load = 1'b1; dly_val = DLY_W'(T_CAS - 1);
            end
            ST_COL: if (dly_done) begin
                rd_cap = !wr_q;
                nxt = ST_PAGE; dly_load = 1'b1; dly_val = DLY_W'(T_CP - 1);
            end
            ST_PAGE: if (dly_done) begin
                if (ref_pend || row_expired || (req_valid && !same_row)) begin
                    nxt = ST_PRE; dly_load = 1'b1; dly_val = DLY_W'(T_RP - 1);
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        accept = 1'b1; nxt = ST_CSET;
                    end
                end
            end
            ST_PRE: if (dly_done) nxt = ST_IDLE;
            ST_REFC: if (dly_done) begin
                nxt = ST_REFR; dly_load = 1'b1; dly_val = DLY_W'(T_RASR - 1);
            end
            ST_REFR: if (dly_done) begin
                ref_ack = ref_pend;
                nxt = ST_PRE; dly_load = 1'b1; dly_val = DLY_W'(T_RP - 1);
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_PWRUP;
            row_q     <= '0;
            col_q     <= '0;
            wr_q      <= 1'b0;
            wd_q      <= '0;
            init_left <= INIT_W'(N_INIT_REF);
            rd_data   <= '0;
            rd_valid  <= 1'b0;
        end else begin
            state    <= nxt;
            rd_valid <= rd_cap;
            if (rd_cap)
                rd_data <= dram_dq_in;
            if (accept) begin
                row_q <= req_addr[2*ROW_W-1:ROW_W];
                col_q <= req_addr[ROW_W-1:0];
                wr_q  <= req_write;
                wd_q  <= req_wdata;
            end
            if (state == ST_REFR && dly_done && !init_done)
                init_left <= init_left - 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        dram_ras_n  = 1'b1;
        dram_cas_n  = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        dram_a      = '0;
        dram_dq_out = wd_q;
        row_active  = 1'b0;
        unique case (state)
            ST_ACT: begin
                dram_ras_n = 1'b0; dram_a = row_q; row_active = 1'b1;
            end
            ST_CSET: begin
                dram_ras_n = 1'b0; dram_a = col_q; row_active = 1'b1;
                dram_we_n  = !wr_q; dram_dq_oe = wr_q;
            end
            ST_COL: begin
                dram_ras_n = 1'b0; dram_cas_n = 1'b0; dram_a = col_q;
                row_active = 1'b1;
                dram_we_n  = !wr_q; dram_dq_oe = wr_q; dram_oe_n = wr_q;
            end
            ST_PAGE: begin
                dram_ras_n = 1'b0; dram_a = col_q; row_active = 1'b1;
            end
            ST_REFC: dram_cas_n = 1'b0;
            ST_REFR: begin
                dram_cas_n = 1'b0; dram_ras_n = 1'b0; row_active = 1'b1;
            end
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    logic [RASC_W-1:0] ras_low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ras_low_cnt <= '0;
        else if (dram_ras_n)
            ras_low_cnt <= '0;
        else if (ras_low_cnt != RASC_W'(T_RAS_MAX + 1))
            ras_low_cnt <= ras_low_cnt + 1'b1;
    end

    // R8
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low_cnt <= RASC_W'(T_RAS_MAX));

    // R4
    we_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

    // R4
    oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);

    // R10
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(!dram_cas_n) && dram_we_n));

    // R5
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R9
    ready_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> dram_cas_n);
endmodule

// File: tb/page_dram_ctrl_bench.sv
module page_dram_ctrl_bench;
    localparam int T_PWRUP = 40;
    localparam int N_INIT  = 8;
    localparam int REF_INT = 300;
    localparam int T_RMAX  = 120;
    localparam int T_RP    = 8;
    localparam int T_RCD   = 3;
    localparam int T_CAS   = 3;
    localparam int T_CP    = 2;
    localparam int T_CSR   = 2;
    localparam int T_RASR  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [3:0] rd_data, dq_out, dq_in;
    logic [9:0] dram_a;

    always #4 clk = ~clk;

    page_dram_ctrl #(
        .T_PWRUP(T_PWRUP), .N_INIT_REF(N_INIT), .REF_INTERVAL(REF_INT),
        .T_RAS_MAX(T_RMAX), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_CP(T_CP), .T_CSR(T_CSR), .T_RASR(T_RASR)
    ) u_page_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .dram_a(dram_a),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
        .dram_oe_n(oe_n), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe),
        .dram_dq_in(dq_in)
    );

    int vectors = 0;
    int errors  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural DRAM and shadow memory
    logic [3:0] dram_mem [int];
    logic [3:0] shadow   [int];
    logic [3:0] model_rd = 4'h0;
    int issued_addr[$];
    bit issued_wr[$];
    logic [3:0] issued_d[$];
    logic [3:0] exp_rd[$];

    assign dq_in = (!ras_n && !cas_n && !oe_n) ? model_rd : 4'h5;

    function automatic logic [3:0] rd_mem(input int k);
        return dram_mem.exists(k) ? dram_mem[k] : 4'h0;
    endfunction

    function automatic logic [3:0] rd_shadow(input int k);
        return shadow.exists(k) ? shadow[k] : 4'h0;
    endfunction

    // pin monitor: runs on every falling edge
    bit p_ras = 1, p_cas = 1;
    bit p_we = 1;
    int ras_hi = 0, ras_lo = 0, cas_hi = 0, cas_lo = 0;
    int cyc = 0, ras_falls = 0, refreshes = 0, last_ref = 0;
    bit seen_ready = 0;
    bit col_phase = 0;
    logic [9:0] row_lat = '0;

    always @(negedge clk) if (rst_n) begin
        if (cyc < T_PWRUP) begin
            // R1
            check(ras_n && cas_n && we_n && oe_n && !req_ready, "R1",
                  {ras_n, cas_n, we_n, oe_n, req_ready}, 5'b11110);
        end
        if (req_ready && !seen_ready) begin
            seen_ready = 1;
            // R2
            check(refreshes >= N_INIT, "R2", refreshes, N_INIT);
        end
        if (!ras_n) begin
            // R8
            check(ras_lo + 1 <= T_RMAX, "R8", ras_lo + 1, T_RMAX);
        end
        if (p_ras && !ras_n) begin
            ras_falls++;
            // R7
            check(ras_hi >= T_RP, "R7", ras_hi, T_RP);
            if (!cas_n) begin
                // R10
                check(cas_lo >= T_CSR, "R10", cas_lo, T_CSR);
            end else begin
                row_lat = dram_a;
            end
        end
        if (p_cas && !cas_n && ras_n) begin
            refreshes++;
            // R10
            check(we_n == 1'b1, "R10", we_n, 1);
            if (refreshes > N_INIT + 1) begin
                // R11
                check(cyc - last_ref <= REF_INT + 32, "R11", cyc - last_ref, REF_INT + 32);
            end
            last_ref = cyc;
        end
        if (p_cas && !cas_n && !ras_n) begin
            col_phase = 1;
            // R9
            check(ras_lo >= T_RCD, "R9", ras_lo, T_RCD);
            check(cas_hi >= T_CP, "R9", cas_hi, T_CP);
            if (issued_addr.size() == 0) begin
                check(0, "R3", 0, 1);
            end else begin
                int ea;
                bit ew;
                logic [3:0] ed;
                ea = issued_addr.pop_front();
                ew = issued_wr.pop_front();
                ed = issued_d.pop_front();
                // R3
                check({row_lat, dram_a} == 20'(ea), "R3", int'({row_lat, dram_a}), ea);
                check(we_n == !ew, "R4", we_n, !ew);
                if (ew) begin
                    // R4
                    check(p_we == 1'b0, "R4", p_we, 0);
                    check(dq_oe && oe_n && dq_out == ed, "R4", dq_out, ed);
                    dram_mem[ea] = dq_out;
                end else begin
                    model_rd = rd_mem(int'({row_lat, dram_a}));
                end
            end
        end
        if (!p_cas && cas_n && col_phase) begin
            col_phase = 0;
            // R9
            check(cas_lo >= T_CAS, "R9", cas_lo, T_CAS);
        end
        if (rd_valid) begin
            if (exp_rd.size() == 0) begin
                check(0, "R5", rd_data, -1);
            end else begin
                logic [3:0] e;
                e = exp_rd.pop_front();
                // R5
                check(rd_data == e, "R5", rd_data, e);
            end
        end
        if (ras_n) begin ras_hi++; ras_lo = 0; end else begin ras_lo++; ras_hi = 0; end
        if (cas_n) begin cas_hi++; cas_lo = 0; end else begin cas_lo++; cas_hi = 0; end
        p_ras = ras_n; p_cas = cas_n; p_we = we_n;
        cyc++;
    end

    task automatic issue(input logic [19:0] ad, input bit w, input logic [3:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_addr = ad; req_write = w; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        issued_addr.push_back(int'(ad));
        issued_wr.push_back(w);
        issued_d.push_back(d);
        if (w) shadow[int'(ad)] = d;
        else exp_rd.push_back(rd_shadow(int'(ad)));
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain;
        while (issued_addr.size() != 0 || exp_rd.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ras_n && cas_n && we_n && oe_n && !req_ready && !rd_valid, "R1",
              {ras_n, cas_n, we_n, oe_n, req_ready, rd_valid}, 6'b111100);
        rst_n = 1'b1;

        // writes spread over rows and columns, then read back
        for (int i = 0; i < 12; i++)
            issue({10'(i * 97 % 1024), 10'(i * 211 % 1024)}, 1'b1, 4'(i ^ 9));
        issue({10'd1023, 10'd1023}, 1'b1, 4'hF);
        issue({10'd0, 10'd0}, 1'b1, 4'h6);
        for (int i = 0; i < 12; i++)
            issue({10'(i * 97 % 1024), 10'(i * 211 % 1024)}, 1'b0, 4'h0);
        issue({10'd1023, 10'd1023}, 1'b0, 4'h0);
        issue({10'd0, 10'd0}, 1'b0, 4'h0);
        issue({10'd512, 10'd7}, 1'b0, 4'h0);   // never written: expect 0
        drain();

        // R6: same-row burst right after a refresh uses one row opening
        begin
            int r0, f0;
            r0 = refreshes;
            while (refreshes == r0) @(negedge clk);
            repeat (T_CSR + T_RASR + 4) @(negedge clk);
            f0 = ras_falls;
            for (int i = 0; i < 6; i++)
                issue({10'd333, 10'(i * 5)}, i[0], 4'(i + 3));
            drain();
            check(ras_falls - f0 == 1, "R6", ras_falls - f0, 1);
        end
        for (int i = 0; i < 6; i++)
            issue({10'd333, 10'(i * 5)}, 1'b0, 4'h0);
        drain();

        // R8: long same-row sequence forces the row to reopen
        begin
            int f0;
            f0 = ras_falls;
            for (int i = 0; i < 40; i++)
                issue({10'd44, 10'(i)}, 1'b1, 4'(i));
            drain();
            check(ras_falls - f0 >= 2, "R8", ras_falls - f0, 2);
        end
        for (int i = 0; i < 40; i += 7)
            issue({10'd44, 10'(i)}, 1'b0, 4'h0);

        // alternating rows
        for (int i = 0; i < 8; i++)
            issue({10'(i[0] ? 900 : 12), 10'(i)}, 1'b1, 4'(~i));
        for (int i = 0; i < 8; i++)
            issue({10'(i[0] ? 900 : 12), 10'(i)}, 1'b0, 4'h0);
        drain();

        // idle stretch: R11 refresh spacing keeps being checked
        repeat (1500) @(negedge clk);
        check(refreshes >= N_INIT + 5, "R11", refreshes, N_INIT + 5);
        finish_run();
    end
endmodule